// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the working registers of a processor core that switches between several privilege modes. Software always names sixteen registers, numbered 0 to 15, plus a current status word. Behind those numbers sit 31 physical data registers. The low eight and register 15 (the program counter) are the same storage in every mode. Registers 8 to 12 have a second copy that only the fast interrupt mode sees. Registers 13 (stack pointer) and 14 (link) have a private pair for each of the five exception modes. Six status registers complete the storage: one current status word shared by all modes, and one saved status word for each exception mode.

The core presents a 5-bit mode value every cycle. That value steers two combinational read ports and one write port to the right physical entries. A current-status port and a saved-status port also follow the mode. The saved-status port reaches the saved word that belongs to the present mode. Decode, arithmetic and the policy for changing modes live outside this block. Writes take effect at the rising clock edge. A read in the same cycle as a write to the same entry still returns the old contents.

Top module: `banked_regfile`

## Requirements
- R1: After a synchronous active-low reset, every physical data register, the current status word and all five saved status words read as zero.
- R2: The mode input selects a bank as follows: 5'b10001 fast interrupt, 5'b10010 interrupt, 5'b10011 supervisor, 5'b10111 abort, 5'b11011 undefined. User (5'b10000), system (5'b11111) and any other encoding all use the user bank.
- R3: Registers 0 to 7 and register 15 name the same physical storage in every mode.
- R4: Registers 8 to 12 are shared by all modes except fast interrupt, which has its own five copies.
- R5: Registers 13 and 14 are private to each of the five exception modes, and user and system modes share one pair.
- R6: The two read ports are combinational and independent, so each returns the register its own address names in the current mode.
- R7: A write lands at the rising edge and changes only the one physical register it targets. A read of that register in the same cycle returns the previous value.
- R8: The current status word is one register shared by all modes. It is loaded from cpsr_wdata at the edge when cpsr_we is high.
- R9: Each exception mode has one saved status word. The saved-status port reads and writes the word of the current mode.
- R10: In the user bank the saved-status port reads zero, and writes through it change no saved status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 5 | Current processor mode encoding |
| rd_a_addr | input | 4 | Register number for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_addr | input | 4 | Register number for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable for the data register write port |
| wr_addr | input | 4 | Register number for the write port |
| wr_data | input | 32 | Write data |
| cpsr_we | input | 1 | Load enable for the current status word |
| cpsr_wdata | input | 32 | New current status word |
| cpsr_rdata | output | 32 | Current status word |
| spsr_we | input | 1 | Write enable for the saved status word of the current mode |
| spsr_wdata | input | 32 | New saved status word |
| spsr_rdata | output | 32 | Saved status word of the current mode, zero in the user bank |

## Verification
The assertions check four things on every cycle. A write followed by a read of the same register number in an unchanged bank returns the written data. A physical entry changes only when the write port targets it. The current status word holds when its enable is low. A saved-status write in the user bank leaves all saved words alone. The directed scenarios show what no single-cycle property can: which copy each mode sees for registers 8 to 14. They also show that system mode and unlisted encodings fall back to the user copies, that a same-cycle read returns the old value, and that each exception mode reaches its own saved word.

// File: rtl/bankreg_pkg.sv
// Package: shared types and the architectural-to-physical mapping for the
// mode-banked register file. Assumes 16 architectural registers, 31 physical
// data registers and five exception modes with saved status words.
package bankreg_pkg;

    localparam int ARCH_W    = 4;
    localparam int MODE_W    = 5;
    localparam int NUM_PHYS  = 31;
    localparam int PIDX_W    = $clog2(NUM_PHYS);
    localparam int NUM_SAVED = 5;
    localparam int SIDX_W    = $clog2(NUM_SAVED);

    localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;

    typedef enum logic [2:0] {
        BANK_USR = 3'd0,
        BANK_FIQ = 3'd1,
        BANK_IRQ = 3'd2,
        BANK_SVC = 3'd3,
        BANK_ABT = 3'd4,
        BANK_UND = 3'd5
    } bank_e;

    // Physical layout: 0..15 user view, 16..22 fast interrupt r8..r14,
    // then one r13/r14 pair each for interrupt, supervisor, abort, undefined.
    function automatic logic [PIDX_W-1:0] phys_index(bank_e b, logic [ARCH_W-1:0] a);
        logic [PIDX_W-1:0] base;
        base = PIDX_W'(a);
        phys_index = base;
        if (a >= 4'd8 && a <= 4'd12) begin
            if (b == BANK_FIQ) phys_index = base + PIDX_W'(8);
        end else if (a == 4'd13 || a == 4'd14) begin
            case (b)
                BANK_FIQ: phys_index = base + PIDX_W'(8);
                BANK_IRQ: phys_index = base + PIDX_W'(10);
                BANK_SVC: phys_index = base + PIDX_W'(12);
                BANK_ABT: phys_index = base + PIDX_W'(14);
                BANK_UND: phys_index = base + PIDX_W'(16);
                default:  phys_index = base;
            endcase
        end
    endfunction

endpackage

// File: rtl/brf_mode_decode.sv
// Module: turns the 5-bit mode input into a bank selector.
// Assumes user, system and every unlisted encoding share the user bank.
module brf_mode_decode
    import bankreg_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output bank_e             bank_o
);

    // Map each exception mode encoding to its bank, everything else to user.
    always_comb begin
        case (mode_i)
            MODE_FIQ: bank_o = BANK_FIQ;
            MODE_IRQ: bank_o = BANK_IRQ;
            MODE_SVC: bank_o = BANK_SVC;
            MODE_ABT: bank_o = BANK_ABT;
            MODE_UND: bank_o = BANK_UND;
            default:  bank_o = BANK_USR;
        endcase
    end

endmodule

// File: rtl/brf_index_map.sv
// Module: translates one architectural register number into a physical
// entry index for the given bank. Purely combinational.
module brf_index_map
    import bankreg_pkg::*;
(
    input  bank_e               bank_i,
    input  logic [ARCH_W-1:0]   arch_i,
    output logic [PIDX_W-1:0]   phys_o
);

    // Apply the banking rule from the package.
    always_comb phys_o = phys_index(bank_i, arch_i);

endmodule

// File: rtl/brf_gpr_store.sv
// Module: the 31 physical data registers with two combinational read ports
// and one write port. Assumes indices arrive already mapped; an index past
// the last entry reads as zero and is never written.
module brf_gpr_store
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [PIDX_W-1:0]   wr_idx,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [PIDX_W-1:0]   rd_a_idx,
    output logic [DATA_W-1:0]   rd_a_data,
    input  logic [PIDX_W-1:0]   rd_b_idx,
    output logic [DATA_W-1:0]   rd_b_data
);

    localparam logic [PIDX_W-1:0] LAST_IDX = PIDX_W'(NUM_PHYS - 1);

    logic [DATA_W-1:0] regs_q [NUM_PHYS];

    for (genvar i = 0; i < NUM_PHYS; i++) begin : g_entry
        // Clear on reset, load when the write port targets this entry.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[i] <= '0;
            else if (wr_en && wr_idx == PIDX_W'(i))
                regs_q[i] <= wr_data;
        end

        // R7
        entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_idx == PIDX_W'(i)) |=> $stable(regs_q[i]))
            else $error("physical entry %0d changed without a write", i);
    end

    // Read port A: select the addressed entry.
    always_comb rd_a_data = (rd_a_idx <= LAST_IDX) ? regs_q[rd_a_idx] : '0;

    // Read port B: select the addressed entry.
    always_comb rd_b_data = (rd_b_idx <= LAST_IDX) ? regs_q[rd_b_idx] : '0;

endmodule

// File: rtl/brf_status_store.sv
// Module: the shared current status word and one saved status word per
// exception mode. Assumes the user bank owns no saved word, so the saved
// port reads zero and ignores writes there.
module brf_status_store
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  bank_e               bank_i,
    input  logic                cpsr_we,
    input  logic [DATA_W-1:0]   cpsr_wdata,
    output logic [DATA_W-1:0]   cpsr_rdata,
    input  logic                spsr_we,
    input  logic [DATA_W-1:0]   spsr_wdata,
    output logic [DATA_W-1:0]   spsr_rdata
);

    logic [DATA_W-1:0]                  cpsr_q;
    logic [NUM_SAVED-1:0][DATA_W-1:0]   saved_q;
    logic                               has_saved;
    logic [SIDX_W-1:0]                  saved_sel;

    // Work out whether the bank owns a saved word and which one.
    always_comb begin
        has_saved = (bank_i != BANK_USR);
        saved_sel = has_saved ? SIDX_W'(bank_i - BANK_FIQ) : '0;
    end

    // Current status word: shared by all modes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cpsr_q <= '0;
        else if (cpsr_we)
            cpsr_q <= cpsr_wdata;
    end

    for (genvar s = 0; s < NUM_SAVED; s++) begin : g_saved
        // Saved word for one exception mode, written only in that mode.
        always_ff @(posedge clk) begin
            if (!rst_n)
                saved_q[s] <= '0;
            else if (spsr_we && has_saved && saved_sel == SIDX_W'(s))
                saved_q[s] <= spsr_wdata;
        end
    end

    // Drive the status read ports.
    always_comb begin
        cpsr_rdata = cpsr_q;
        spsr_rdata = has_saved ? saved_q[saved_sel] : '0;
    end

    // R8
    cpsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpsr_we |=> $stable(cpsr_q))
        else $error("current status changed without enable");

    // R10
    user_saved_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spsr_we && bank_i == BANK_USR) |=> $stable(saved_q))
        else $error("saved status changed by a user-bank write");

endmodule

// File: rtl/banked_regfile.sv
// Module: top of the mode-banked register file. Decodes the mode, maps the
// three register addresses to physical entries and hosts the data and
// status storage. Assumes the mode input is steady within a cycle.
module banked_regfile
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MODE_W-1:0]   mode_i,
    input  logic [ARCH_W-1:0]   rd_a_addr,
    output logic [DATA_W-1:0]   rd_a_data,
    input  logic [ARCH_W-1:0]   rd_b_addr,
    output logic [DATA_W-1:0]   rd_b_data,
    input  logic                wr_en,
    input  logic [ARCH_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                cpsr_we,
    input  logic [DATA_W-1:0]   cpsr_wdata,
    output logic [DATA_W-1:0]   cpsr_rdata,
    input  logic                spsr_we,
    input  logic [DATA_W-1:0]   spsr_wdata,
    output logic [DATA_W-1:0]   spsr_rdata
);

    bank_e              bank;
    logic [PIDX_W-1:0]  rd_a_idx;
    logic [PIDX_W-1:0]  rd_b_idx;
    logic [PIDX_W-1:0]  wr_idx;

    brf_mode_decode u_decode (
        .mode_i (mode_i),
        .bank_o (bank)
    );

    brf_index_map u_map_rd_a (.bank_i(bank), .arch_i(rd_a_addr), .phys_o(rd_a_idx));
    brf_index_map u_map_rd_b (.bank_i(bank), .arch_i(rd_b_addr), .phys_o(rd_b_idx));
    brf_index_map u_map_wr   (.bank_i(bank), .arch_i(wr_addr),   .phys_o(wr_idx));

    brf_gpr_store #(.DATA_W(DATA_W)) u_gpr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_a_idx  (rd_a_idx),
        .rd_a_data (rd_a_data),
        .rd_b_idx  (rd_b_idx),
        .rd_b_data (rd_b_data)
    );

    brf_status_store #(.DATA_W(DATA_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank_i     (bank),
        .cpsr_we    (cpsr_we),
        .cpsr_wdata (cpsr_wdata),
        .cpsr_rdata (cpsr_rdata),
        .spsr_we    (spsr_we),
        .spsr_wdata (spsr_wdata),
        .spsr_rdata (spsr_rdata)
    );

    // R6
    read_a_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_addr) == rd_a_addr && $past(bank) == bank)
        |-> rd_a_data == $past(wr_data))
        else $error("port A missed the last write");

    // R6
    read_b_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_addr) == rd_b_addr && $past(bank) == bank)
        |-> rd_b_data == $past(wr_data))
        else $error("port B missed the last write");

    // R3
    shared_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_addr) == rd_a_addr
         && (rd_a_addr < 4'd8 || rd_a_addr == 4'd15))
        |-> rd_a_data == $past(wr_data))
        else $error("shared register differs across modes");

endmodule

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;

    localparam logic [4:0] M_USR = 5'b10000;
    localparam logic [4:0] M_FIQ = 5'b10001;
    localparam logic [4:0] M_IRQ = 5'b10010;
    localparam logic [4:0] M_SVC = 5'b10011;
    localparam logic [4:0] M_ABT = 5'b10111;
    localparam logic [4:0] M_UND = 5'b11011;
    localparam logic [4:0] M_SYS = 5'b11111;
    localparam logic [4:0] M_BAD = 5'b00000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode_i = M_USR;
    logic [3:0]  rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0, cpsr_we = 1'b0, spsr_we = 1'b0;
    logic [31:0] cpsr_wdata = '0, cpsr_rdata, spsr_wdata = '0, spsr_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    banked_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cpsr_we(cpsr_we), .cpsr_wdata(cpsr_wdata), .cpsr_rdata(cpsr_rdata),
        .spsr_we(spsr_we), .spsr_wdata(spsr_wdata), .spsr_rdata(spsr_rdata)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(logic [4:0] m, logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        mode_i = m; wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [4:0] m, logic [3:0] a, logic [31:0] exp);
        @(negedge clk);
        mode_i = m; rd_a_addr = a; rd_b_addr = a;
        #1;
        check(req, $sformatf("mode %b r%0d port A", m, a), rd_a_data, exp);
        check(req, $sformatf("mode %b r%0d port B", m, a), rd_b_data, exp);
    endtask

    task automatic wr_spsr(logic [4:0] m, logic [31:0] d);
        @(negedge clk);
        mode_i = m; spsr_we = 1'b1; spsr_wdata = d;
        @(negedge clk);
        spsr_we = 1'b0;
    endtask

    task automatic spsr_chk(string req, logic [4:0] m, logic [31:0] exp);
        @(negedge clk);
        mode_i = m;
        #1;
        check(req, $sformatf("saved status in mode %b", m), spsr_rdata, exp);
    endtask

    // R1: everything reads zero after reset
    task automatic t_reset();
        for (int a = 0; a < 16; a++) rd_chk("R1", M_USR, 4'(a), 32'h0);
        rd_chk("R1", M_FIQ, 4'd10, 32'h0);
        rd_chk("R1", M_UND, 4'd14, 32'h0);
        check("R1", "current status", cpsr_rdata, 32'h0);
        spsr_chk("R1", M_SVC, 32'h0);
        spsr_chk("R1", M_FIQ, 32'h0);
    endtask

    // R3: low registers and r15 common to all modes
    task automatic t_shared();
        wr_reg(M_USR, 4'd3, 32'h1111_0003);
        wr_reg(M_FIQ, 4'd15, 32'h1111_000F);
        wr_reg(M_UND, 4'd0, 32'h1111_0000);
        rd_chk("R3", M_SVC, 4'd3, 32'h1111_0003);
        rd_chk("R3", M_FIQ, 4'd3, 32'h1111_0003);
        rd_chk("R3", M_USR, 4'd15, 32'h1111_000F);
        rd_chk("R3", M_ABT, 4'd15, 32'h1111_000F);
        rd_chk("R3", M_SYS, 4'd0, 32'h1111_0000);
    endtask

    // R4: r8..r12 split only for fast interrupt
    task automatic t_fiq_bank();
        wr_reg(M_USR, 4'd9, 32'hAAAA_0009);
        wr_reg(M_FIQ, 4'd9, 32'hBBBB_0009);
        wr_reg(M_IRQ, 4'd12, 32'hCCCC_000C);
        rd_chk("R4", M_USR, 4'd9, 32'hAAAA_0009);
        rd_chk("R4", M_IRQ, 4'd9, 32'hAAAA_0009);
        rd_chk("R4", M_SVC, 4'd9, 32'hAAAA_0009);
        rd_chk("R4", M_FIQ, 4'd9, 32'hBBBB_0009);
        rd_chk("R4", M_SYS, 4'd12, 32'hCCCC_000C);
        rd_chk("R4", M_FIQ, 4'd12, 32'h0);
    endtask

    // R5 and R2: private r13/r14 per exception mode, system shares user
    task automatic t_private();
        wr_reg(M_USR, 4'd13, 32'h5000_0000);
        wr_reg(M_FIQ, 4'd13, 32'h5000_0001);
        wr_reg(M_IRQ, 4'd13, 32'h5000_0002);
        wr_reg(M_SVC, 4'd13, 32'h5000_0003);
        wr_reg(M_ABT, 4'd13, 32'h5000_0004);
        wr_reg(M_UND, 4'd13, 32'h5000_0005);
        wr_reg(M_SVC, 4'd14, 32'h6000_0003);
        rd_chk("R5", M_USR, 4'd13, 32'h5000_0000);
        rd_chk("R5", M_SYS, 4'd13, 32'h5000_0000);
        rd_chk("R2", M_FIQ, 4'd13, 32'h5000_0001);
        rd_chk("R2", M_IRQ, 4'd13, 32'h5000_0002);
        rd_chk("R2", M_SVC, 4'd13, 32'h5000_0003);
        rd_chk("R2", M_ABT, 4'd13, 32'h5000_0004);
        rd_chk("R2", M_UND, 4'd13, 32'h5000_0005);
        rd_chk("R5", M_SVC, 4'd14, 32'h6000_0003);
        rd_chk("R5", M_ABT, 4'd14, 32'h0);
        rd_chk("R5", M_USR, 4'd14, 32'h0);
    endtask

    // R6: both ports read different registers at once
    task automatic t_dual_read();
        @(negedge clk);
        mode_i = M_SVC; rd_a_addr = 4'd3; rd_b_addr = 4'd13;
        #1;
        check("R6", "port A r3", rd_a_data, 32'h1111_0003);
        check("R6", "port B r13 svc", rd_b_data, 32'h5000_0003);
    endtask

    // R7: same-cycle read sees the old value, new value after the edge
    task automatic t_read_during_write();
        wr_reg(M_USR, 4'd5, 32'hAAAA_0005);
        @(negedge clk);
        mode_i = M_USR; rd_a_addr = 4'd5; rd_b_addr = 4'd6;
        wr_en = 1'b1; wr_addr = 4'd5; wr_data = 32'h5555_0005;
        #1;
        check("R7", "r5 during write", rd_a_data, 32'hAAAA_0005);
        @(posedge clk);
        #1;
        check("R7", "r5 after edge", rd_a_data, 32'h5555_0005);
        check("R7", "r6 untouched", rd_b_data, 32'h0);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R8: current status shared by all modes
    task automatic t_cpsr();
        @(negedge clk);
        mode_i = M_USR; cpsr_we = 1'b1; cpsr_wdata = 32'h6000_00D3;
        @(negedge clk);
        cpsr_we = 1'b0; mode_i = M_FIQ;
        #1;
        check("R8", "status in fiq", cpsr_rdata, 32'h6000_00D3);
        @(negedge clk);
        mode_i = M_UND; cpsr_wdata = 32'hFFFF_FFFF;
        #1;
        check("R8", "status without enable", cpsr_rdata, 32'h6000_00D3);
    endtask

    // R9: one saved word per exception mode
    task automatic t_spsr();
        wr_spsr(M_FIQ, 32'h7000_0011);
        wr_spsr(M_IRQ, 32'h7000_0012);
        wr_spsr(M_SVC, 32'h7000_0013);
        wr_spsr(M_ABT, 32'h7000_0017);
        wr_spsr(M_UND, 32'h7000_001B);
        spsr_chk("R9", M_FIQ, 32'h7000_0011);
        spsr_chk("R9", M_IRQ, 32'h7000_0012);
        spsr_chk("R9", M_SVC, 32'h7000_0013);
        spsr_chk("R9", M_ABT, 32'h7000_0017);
        spsr_chk("R9", M_UND, 32'h7000_001B);
    endtask

    // R10: user bank has no saved word
    task automatic t_spsr_user();
        wr_spsr(M_USR, 32'hDEAD_BEEF);
        wr_spsr(M_SYS, 32'hDEAD_BEEF);
        spsr_chk("R10", M_USR, 32'h0);
        spsr_chk("R10", M_SYS, 32'h0);
        spsr_chk("R10", M_FIQ, 32'h7000_0011);
        spsr_chk("R10", M_SVC, 32'h7000_0013);
        spsr_chk("R10", M_UND, 32'h7000_001B);
    endtask

    // R2: unlisted encoding behaves as the user bank
    task automatic t_bad_mode();
        rd_chk("R2", M_BAD, 4'd13, 32'h5000_0000);
        rd_chk("R2", M_BAD, 4'd9, 32'hAAAA_0009);
        wr_reg(M_BAD, 4'd14, 32'h8000_000E);
        rd_chk("R2", M_USR, 4'd14, 32'h8000_000E);
        rd_chk("R2", M_IRQ, 4'd14, 32'h0);
        spsr_chk("R2", M_BAD, 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_shared();
        t_fiq_bank();
        t_private();
        t_dual_read();
        t_read_during_write();
        t_cpsr();
        t_spsr();
        t_spsr_user();
        t_bad_mode();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule